// File: doc/BRIEF.md
# Soft-Bit Block Deinterleaver

This block undoes the column-write, row-read bit interleaving of a satellite broadcast receiver, working on soft bits one frame at a time. Soft bits arrive with valid, start and end markers. The frame's modulation code and size flag arrive together with the start beat. Each frame is stored in one half of an inferred dual-port RAM. The two halves act as ping-pong buffers, so one frame can be written while the frame before it is read out. Read addresses are a per-frame offset, built with counters and adders and no multiplier, added to the base of the frame's half.

The row and column counts are chosen per frame from its modulation and size. The column count is 1, 3, 4 or 5. The row count is the frame length divided by the column count. Parameters of completed frames wait in a two-entry queue, so every readout uses the geometry of the frame it is draining, even while the next frame, possibly with a different geometry, is being written.

With full-size frames (`NORM_BITS`=64800, `SHORT_BITS`=16200), the row counts are:

| Modulation | Columns | Rows (normal) | Rows (short) |
|------------|---------|---------------|--------------|
| 32-APSK    | 5       | 12960         | 3240         |
| 16-APSK    | 4       | 16200         | 4050         |
| 8-PSK      | 3       | 21600         | 5400         |
| QPSK       | 1       | 64800         | 16200        |

The defaults are smaller so that the RAM stays modest.

Top module: `softbit_deinterleaver`

## Requirements
- R1: A frame is the run of `in_valid` beats from a beat with `in_start` up to and including a beat with `in_end`. `in_mod` and `in_short` are sampled only on the start beat; their values on later beats have no effect.
- R2: `in_mod` codes 0, 1, 2, 3 give 1, 3, 4, 5 columns (QPSK, 8-PSK, 16-APSK, 32-APSK). `in_short`=1 selects a frame length of `SHORT_BITS` and 0 selects `NORM_BITS`. The row count is the frame length divided by the column count.
- R3: Output beat k of a frame carries the input beat at position (k mod rows)*cols + (k div rows) of that frame.
- R4: With one column (code 0), the frame is output in its input order.
- R5: `out_start` is high only on the first output beat of a frame and `out_end` only on the last. The beats of one frame leave on consecutive cycles, and `out_valid` rises only together with `out_start`.
- R6: Readout of a frame starts only after its end beat is written. When the read side is idle, the first output beat appears 2 clock cycles after the clock edge that captures the end beat.
- R7: Two buffers let equal-length frames stream back to back with no idle input cycles. The output then runs without a gap between frames.
- R8: Each readout uses the geometry of its own frame, even when frames of different modulation follow each other directly.
- R9: `in_valid` beats that do not belong to an open frame are ignored. `in_start` and `in_end` have no effect when `in_valid` is low.
- R10: A new start beat inside an open frame discards the partial frame. Only the restarted frame is output.
- R11: While reset is asserted, `out_valid` is low. Frames that were complete but not yet read out when reset was applied are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input soft bit valid |
| in_start | input | 1 | First soft bit of a frame |
| in_end | input | 1 | Last soft bit of a frame |
| in_mod | input | 2 | Modulation code, sampled with the start beat |
| in_short | input | 1 | Short frame flag, sampled with the start beat |
| in_bits | input | SBW | Input soft bit |
| out_valid | output | 1 | Output soft bit valid |
| out_start | output | 1 | First output soft bit of a frame |
| out_end | output | 1 | Last output soft bit of a frame |
| out_bits | output | SBW | Deinterleaved soft bit |

## Verification
The bench builds the block with `NORM_BITS`=120 and `SHORT_BITS`=60. Both lengths divide by 3, 4 and 5, so all eight modulation and size geometries are run to completion within a few hundred cycles. Every output beat of every frame is compared against an order computed in the bench by interleaving known data. The small lengths also make it cheap to cover back-to-back streaming across both buffers, mixed geometries in flight, restarts, stray beats and reset during a pending readout.

// File: rtl/softbit_deinterleaver.sv
module softbit_deinterleaver #(
  parameter int SBW        = 8,
  parameter int NORM_BITS  = 1200,
  parameter int SHORT_BITS = 300
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           in_start,
  input  logic           in_end,
  input  logic [1:0]     in_mod,
  input  logic           in_short,
  input  logic [SBW-1:0] in_bits,
  output logic           out_valid,
  output logic           out_start,
  output logic           out_end,
  output logic [SBW-1:0] out_bits
);
  localparam int DEPTH = 2 * NORM_BITS;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(NORM_BITS + 1);

  function automatic logic [2:0] cols_of(input logic [1:0] m);
    case (m)
      2'd0:    return 3'd1;
      2'd1:    return 3'd3;
      2'd2:    return 3'd4;
      default: return 3'd5;
    endcase
  endfunction

  function automatic logic [CW-1:0] rows_of(input logic s, input logic [1:0] m);
    case ({s, m})
      3'b000:  return CW'(NORM_BITS);
      3'b001:  return CW'(NORM_BITS / 3);
      3'b010:  return CW'(NORM_BITS / 4);
      3'b011:  return CW'(NORM_BITS / 5);
      3'b100:  return CW'(SHORT_BITS);
      3'b101:  return CW'(SHORT_BITS / 3);
      3'b110:  return CW'(SHORT_BITS / 4);
      default: return CW'(SHORT_BITS / 5);
    endcase
  endfunction

  logic [SBW-1:0] mem [DEPTH];

  // write side
  logic          wr_open, wr_bank, wr_short;
  logic [1:0]    wr_mod;
  logic [CW-1:0] wr_cnt;

  wire           beat_data = in_valid & (in_start | wr_open);
  wire [CW-1:0]  wr_idx    = in_start ? '0 : wr_cnt;
  wire           wr_done   = beat_data & in_end;
  wire [AW-1:0]  wr_addr   = wr_bank ? AW'(NORM_BITS) + AW'(wr_idx) : AW'(wr_idx);
  wire [3:0]     wr_entry  = {wr_bank, in_start ? in_short : wr_short, in_start ? in_mod : wr_mod};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_open  <= 1'b0;
      wr_bank  <= 1'b0;
      wr_cnt   <= '0;
      wr_mod   <= '0;
      wr_short <= 1'b0;
    end else if (beat_data) begin
      wr_cnt  <= wr_idx + CW'(1);
      wr_open <= ~in_end;
      if (in_start) begin
        wr_mod   <= in_mod;
        wr_short <= in_short;
      end
      if (in_end) wr_bank <= ~wr_bank;
    end

  // parameter queue of completed frames
  logic [3:0] q_mem [2];
  logic       q_wp, q_rp;
  logic [1:0] q_cnt;

  // read side
  logic          rd_act, rd_bank;
  logic [2:0]    rd_cols, rd_c;
  logic [CW-1:0] rd_rows, rd_r, rd_off;

  wire          rd_row_wrap = rd_r == rd_rows - CW'(1);
  wire          rd_last     = rd_row_wrap && rd_c == rd_cols - 3'd1;
  wire          rd_go       = (!rd_act || rd_last) && q_cnt != 2'd0;
  wire [3:0]    q_head      = q_mem[q_rp];
  wire [AW-1:0] rd_addr     = rd_bank ? AW'(NORM_BITS) + AW'(rd_off) : AW'(rd_off);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      q_wp  <= 1'b0;
      q_rp  <= 1'b0;
      q_cnt <= '0;
      q_mem[0] <= '0;
      q_mem[1] <= '0;
    end else begin
      if (wr_done) begin
        q_mem[q_wp] <= wr_entry;
        q_wp <= ~q_wp;
      end
      if (rd_go) q_rp <= ~q_rp;
      q_cnt <= q_cnt + {1'b0, wr_done} - {1'b0, rd_go};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_act  <= 1'b0;
      rd_bank <= 1'b0;
      rd_cols <= 3'd1;
      rd_rows <= CW'(1);
      rd_r    <= '0;
      rd_c    <= '0;
      rd_off  <= '0;
    end else if (rd_go) begin
      rd_act  <= 1'b1;
      rd_bank <= q_head[3];
      rd_cols <= cols_of(q_head[1:0]);
      rd_rows <= rows_of(q_head[2], q_head[1:0]);
      rd_r    <= '0;
      rd_c    <= '0;
      rd_off  <= '0;
    end else if (rd_act) begin
      if (rd_last) begin
        rd_act <= 1'b0;
      end else if (rd_row_wrap) begin
        rd_r   <= '0;
        rd_c   <= rd_c + 3'd1;
        rd_off <= CW'(rd_c) + CW'(1);
      end else begin
        rd_r   <= rd_r + CW'(1);
        rd_off <= rd_off + CW'(rd_cols);
      end
    end

  always_ff @(posedge clk) begin
    if (beat_data && wr_idx < CW'(NORM_BITS)) mem[wr_addr] <= in_bits;
    out_bits <= mem[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_start <= 1'b0;
      out_end   <= 1'b0;
    end else begin
      out_valid <= rd_act;
      out_start <= rd_act && rd_r == '0 && rd_c == '0;
      out_end   <= rd_act && rd_last;
    end
endmodule

// File: rtl/softbit_deinterleaver_chk.sv
module softbit_deinterleaver_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       out_valid,
  input logic       out_start,
  input logic       out_end,
  input logic       push,
  input logic       pop,
  input logic [1:0] q_cnt
);
  // R5
  start_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |-> out_valid);
  // R5
  end_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_end |-> out_valid);
  // R5
  frame_gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_end |=> out_valid);
  // R5
  rise_is_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_start);
  // R5
  after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_end |=> !out_valid || out_start);
  // R7
  queue_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push && q_cnt == 2'd2 |-> pop);
endmodule

bind softbit_deinterleaver softbit_deinterleaver_chk u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_start(out_start),
  .out_end(out_end), .push(wr_done), .pop(rd_go), .q_cnt(q_cnt)
);

// File: tb/softbit_deinterleaver_test.sv
module softbit_deinterleaver_test;
  localparam int NB = 120;
  localparam int SB = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_start = 1'b0, in_end = 1'b0, in_short = 1'b0;
  logic [1:0] in_mod = '0;
  logic [7:0] in_bits = '0;
  logic out_valid, out_start, out_end;
  logic [7:0] out_bits;

  always #5 clk = ~clk;

  softbit_deinterleaver #(.SBW(8), .NORM_BITS(NB), .SHORT_BITS(SB)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .in_end(in_end), .in_mod(in_mod), .in_short(in_short), .in_bits(in_bits),
    .out_valid(out_valid), .out_start(out_start), .out_end(out_end),
    .out_bits(out_bits)
  );

  int total = 0, fails = 0, cyc = 0, end_cyc = 0, frames = 0;
  int first_start = 0, last_end = 0;
  bit lat_on = 0, done = 0;
  string spur_req = "R9";
  logic [9:0] exp_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(0, spur_req, 1, 0);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        check(out_bits == e[7:0], "R3", out_bits, e[7:0]);
        check(out_start == e[9], "R5 start", out_start, e[9]);
        check(out_end == e[8], "R5 end", out_end, e[8]);
      end
      if (out_start && lat_on) begin
        check(cyc - end_cyc == 2, "R6", cyc - end_cyc, 2);
        lat_on = 0;
      end
      if (out_start && frames == 0) first_start = cyc;
      if (out_end) begin
        frames++;
        last_end = cyc;
      end
    end
  end

  task automatic idle_in();
    in_valid = 1'b0; in_start = 1'b0; in_end = 1'b0;
  endtask

  // beats < frame length sends a partial frame without end
  task automatic send_frame(input int m, input bit s, input int seed, input bit gaps,
                            input bit expect_it, input int beats, input bit trail);
    int len, cols, rows;
    logic [7:0] d[NB];
    logic [7:0] x[NB];
    len  = s ? SB : NB;
    cols = (m == 0) ? 1 : (m == 1) ? 3 : (m == 2) ? 4 : 5;
    rows = len / cols;
    for (int i = 0; i < len; i++) d[i] = 8'(seed * 37 + i * 11 + (i >> 3));
    for (int j = 0; j < len; j++) x[j] = d[(j % cols) * rows + j / cols];
    if (expect_it)
      for (int k = 0; k < len; k++) exp_q.push_back({k == 0, k == len - 1, d[k]});
    for (int j = 0; j < beats; j++) begin
      if (gaps && j % 7 == 3) begin
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b1; in_end = 1'b1; in_bits = 8'hA5;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_start = (j == 0);
      in_end   = (j == len - 1);
      in_mod   = (j == 0) ? 2'(m) : ~2'(m);
      in_short = (j == 0) ? s : ~s;
      in_bits  = x[j];
      if (j == len - 1) end_cyc = cyc + 1;
    end
    if (trail) begin
      @(negedge clk);
      idle_in();
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    check(0, "watchdog", cyc, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int f0, e0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R11 reset", out_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R11 after reset", out_valid, 0);

    // R2 R3 R4 R6 R1 R9: every geometry, gapped input, read side idle
    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 4; m++) begin
        f0 = frames; e0 = fails;
        send_frame(m, s[0], m + 4 * s, 1, 1, s ? SB : NB, 1);
        lat_on = 1;
        drain();
        check(frames - f0 == 1, "R2", frames - f0, 1);
        if (m == 0) check(fails == e0, "R4", fails - e0, 0);
        check(fails == e0, "R1", fails - e0, 0);
      end

    // R7: three equal frames back to back, no idle input cycles
    f0 = frames; frames = 0;
    for (int i = 0; i < 3; i++) send_frame(3, 1'b0, 20 + i, 0, 1, NB, i == 2);
    drain();
    check(frames == 3, "R7 frames", frames, 3);
    check(last_end - first_start == 3 * NB - 1, "R7 continuous", last_end - first_start, 3 * NB - 1);
    frames = frames + f0;

    // R8: mixed geometries in flight
    f0 = frames; e0 = fails;
    send_frame(1, 1'b0, 30, 0, 1, NB, 0);
    send_frame(2, 1'b0, 31, 0, 1, NB, 0);
    send_frame(0, 1'b0, 32, 0, 1, NB, 1);
    drain();
    send_frame(3, 1'b1, 33, 0, 1, SB, 0);
    send_frame(1, 1'b1, 34, 0, 1, SB, 0);
    send_frame(2, 1'b1, 35, 0, 1, SB, 1);
    drain();
    check(frames - f0 == 6, "R8 frames", frames - f0, 6);
    check(fails == e0, "R8 data", fails - e0, 0);

    // R9: stray beats outside a frame
    f0 = frames;
    spur_req = "R9";
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_start = 1'b0; in_end = (i % 4 == 3); in_bits = 8'(i * 9);
    end
    @(negedge clk); idle_in();
    repeat (NB) @(negedge clk);
    check(frames == f0, "R9", frames - f0, 0);

    // R10: restart inside an open frame
    f0 = frames; e0 = fails;
    spur_req = "R10";
    send_frame(2, 1'b0, 40, 0, 0, 25, 0);
    send_frame(3, 1'b0, 41, 0, 1, NB, 1);
    drain();
    repeat (NB) @(negedge clk);
    check(frames - f0 == 1, "R10", frames - f0, 1);
    check(fails == e0, "R10 data", fails - e0, 0);

    // R11: reset with a complete frame pending
    f0 = frames;
    spur_req = "R11";
    send_frame(1, 1'b1, 50, 0, 0, SB, 1);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R11 in reset", out_valid, 0);
    rst_n = 1'b1;
    repeat (2 * NB) @(negedge clk);
    check(frames == f0, "R11 dropped", frames - f0, 0);
    send_frame(3, 1'b1, 51, 0, 1, SB, 1);
    drain();
    check(frames - f0 == 1, "R11 recovery", frames - f0, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule